// File: doc/BRIEF.md
# Duplex LCD Drive Waveform Generator

This block produces the drive levels for a seven-segment liquid-crystal display multiplexed two ways. Two backplanes are used. Every segment line carries two segments, one facing each backplane. Each backplane output is a three-level signal. It is handed to an external analog stage as a 2-bit level code: full supply, half supply or zero. Each segment line is a plain two-level output. The voltage generation and the contrast control sit outside this block.

A frame is split into four equal phases, stepped by an external timebase tick. A 64 Hz frame (15.625 ms) needs a tick rate of 256 Hz times `TICKS_PER_PHASE`. In each phase one backplane is driven to full or zero and the other rests at half supply. The driven backplane changes every phase, and its polarity changes every two phases, so neither backplane nor any segment line keeps a DC component over a frame. A segment line is driven opposite to the active backplane when the segment on that backplane is on, and equal to it when that segment is off. With three-level backplanes this gives about 0.79 of the supply RMS across an on segment and about 0.35 across an off one. A test input lights every segment.

Top module: `duplex_lcd_drive`

## Requirements
- R1: While `rst_n` is low, both backplane codes read 2'b01 (mid) and every segment line reads 0. After release the frame starts again at phase 0.
- R2: Backplane level codes are 2'b10 for full, 2'b01 for mid and 2'b00 for zero. Code 2'b11 never appears.
- R3: The phases run 0,1,2,3 and then wrap to 0. In phase 0 backplane 1 is full and backplane 2 is mid. In phase 1 backplane 2 is full and backplane 1 is mid. In phase 2 backplane 1 is zero and backplane 2 is mid. In phase 3 backplane 2 is zero and backplane 1 is mid.
- R4: The phase advances only on the `TICKS_PER_PHASE`-th tick pulse counted since the last advance. Fewer ticks, or no ticks, leave the outputs unchanged.
- R5: In every phase exactly one backplane is at mid.
- R6: When the segment facing the active backplane is on, its segment line is the inverse of that backplane's level (full reads as 1, zero as 0).
- R7: When the segment facing the active backplane is off, its segment line equals that backplane's level.
- R8: Bit 2i of `segState` is the segment on line i facing backplane 1. Bit 2i+1 is the segment on line i facing backplane 2.
- R9: While `testAllOn` is 1, every segment is treated as on, whatever `segState` holds.
- R10: The outputs reflect `segState`, `testAllOn` and the current phase one clock edge after they change.
- R11: While the inputs hold steady, every segment line is 1 in exactly two of the four phases of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| segState | input | 2*NUM_LINES | Segment on/off bits, two per segment line |
| testAllOn | input | 1 | Force every segment on |
| bp1Lvl | output | 2 | Backplane 1 level code |
| bp2Lvl | output | 2 | Backplane 2 level code |
| segLvl | output | NUM_LINES | Segment line levels |

## Verification
Several properties are checked on every cycle once the outputs are valid:
- the level code is always legal, and exactly one backplane rests at mid;
- each segment line is driven against or with the active backplane, according to the previous cycle's segment bit;
- the test input forces the "on" pattern;
- the phase moves only on a completed tick count, and then by exactly one step.

Other behaviour shows only in the bench scenarios: the phase-to-level order over a full frame, the two-of-four balance on each line, the bit-to-backplane mapping under distinct patterns, the one-edge latency, and the restart at phase 0 after a reset taken mid-frame.

// File: rtl/duplex_lcd_pkg.sv
package duplex_lcd_pkg;

  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_FULL = 2'b10;

  // Strobes from the phase sequencer to the level datapath
  typedef struct packed {
    logic bp2Active;   // backplane 2 is the driven one in this phase
    logic activeHigh;  // driven backplane sits at full (else zero)
  } phaseStrobe_t;

endpackage

// File: rtl/duplex_lcd_ctrl.sv
module duplex_lcd_ctrl
  import duplex_lcd_pkg::*;
#(
  parameter int TICKS_PER_PHASE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output phaseStrobe_t strobe
);

  localparam int CNT_W = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1;

  logic       stepFlag;
  logic [1:0] phaseQ;

  generate
    if (TICKS_PER_PHASE == 1) begin : g_direct
      assign stepFlag = tick;
    end else begin : g_divided
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_PHASE - 1);
      logic [CNT_W-1:0] tickCnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tickCnt <= '0;
        end else if (tick) begin
          if (tickCnt == CNT_LAST) tickCnt <= '0;
          else                     tickCnt <= tickCnt + 1'b1;
        end
      end

      assign stepFlag = tick && (tickCnt == CNT_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phaseQ <= 2'd0;
    else if (stepFlag) phaseQ <= phaseQ + 2'd1;
  end

  // Even phases drive backplane 1, odd phases backplane 2; first half of frame is high
  always_comb begin
    strobe.bp2Active  = phaseQ[0];
    strobe.activeHigh = ~phaseQ[1];
  end

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && stepFlag) |=> (phaseQ == $past(phaseQ) + 2'd1));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !stepFlag) |=> $stable(phaseQ));

endmodule

// File: rtl/duplex_lcd_dp.sv
module duplex_lcd_dp
  import duplex_lcd_pkg::*;
#(
  parameter int NUM_LINES = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  phaseStrobe_t           strobe,
  input  logic [2*NUM_LINES-1:0] segState,
  input  logic                   testAllOn,
  output logic [1:0]             bp1Lvl,
  output logic [1:0]             bp2Lvl,
  output logic [NUM_LINES-1:0]   segLvl
);

  localparam int STATE_W = 2 * NUM_LINES;

  logic [STATE_W-1:0]   onVec;
  logic [NUM_LINES-1:0] segNext;
  logic [1:0]           activeLvl;
  logic [1:0]           bp1Next;
  logic [1:0]           bp2Next;
  logic                 outValid;

  assign onVec     = segState | {STATE_W{testAllOn}};
  assign activeLvl = strobe.activeHigh ? LVL_FULL : LVL_ZERO;
  assign bp1Next   = strobe.bp2Active ? LVL_MID : activeLvl;
  assign bp2Next   = strobe.bp2Active ? activeLvl : LVL_MID;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic lineOn;
      assign lineOn     = strobe.bp2Active ? onVec[2*i+1] : onVec[2*i];
      assign segNext[i] = strobe.activeHigh ^ lineOn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp1Lvl   <= LVL_MID;
      bp2Lvl   <= LVL_MID;
      segLvl   <= '0;
      outValid <= 1'b0;
    end else begin
      bp1Lvl   <= bp1Next;
      bp2Lvl   <= bp2Next;
      segLvl   <= segNext;
      outValid <= 1'b1;
    end
  end

  logic actFull;
  assign actFull = (bp1Lvl == LVL_FULL) || (bp2Lvl == LVL_FULL);

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (bp1Lvl != 2'b11) && (bp2Lvl != 2'b11));

  // R5
  one_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> ((bp1Lvl == LVL_MID) != (bp2Lvl == LVL_MID)));

  // R9
  all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(testAllOn)) |-> (segLvl == {NUM_LINES{~actFull}}));

  generate
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
      // R6
      seg_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> (segLvl[k] == (actFull ^ ((bp1Lvl != LVL_MID) ?
                      ($past(segState[2*k]) | $past(testAllOn)) :
                      ($past(segState[2*k+1]) | $past(testAllOn))))));
    end
  endgenerate

endmodule

// File: rtl/duplex_lcd_drive.sv
module duplex_lcd_drive
  import duplex_lcd_pkg::*;
#(
  parameter int NUM_LINES       = 15,
  parameter int TICKS_PER_PHASE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [2*NUM_LINES-1:0] segState,
  input  logic                   testAllOn,
  output logic [1:0]             bp1Lvl,
  output logic [1:0]             bp2Lvl,
  output logic [NUM_LINES-1:0]   segLvl
);

  phaseStrobe_t strobe;

  duplex_lcd_ctrl #(.TICKS_PER_PHASE(TICKS_PER_PHASE)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .strobe (strobe)
  );

  duplex_lcd_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .segState  (segState),
    .testAllOn (testAllOn),
    .bp1Lvl    (bp1Lvl),
    .bp2Lvl    (bp2Lvl),
    .segLvl    (segLvl)
  );

endmodule

// File: tb/sim_duplex_lcd_drive.sv
`timescale 1ns/1ps
module sim_duplex_lcd_drive;

  localparam int NL = 15;
  localparam int TPP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [2*NL-1:0] segState = '0;
  logic          testAllOn = 1'b0;
  logic [1:0]    bp1Lvl, bp2Lvl;
  logic [NL-1:0] segLvl;

  int checks = 0;
  int fails = 0;
  int benchPhase = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  duplex_lcd_drive #(.NUM_LINES(NL), .TICKS_PER_PHASE(TPP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .segState(segState),
    .testAllOn(testAllOn), .bp1Lvl(bp1Lvl), .bp2Lvl(bp2Lvl), .segLvl(segLvl)
  );

  // bit 30 = test input, bits 29:0 = segment state
  localparam logic [30:0] VEC [6] = '{
    {1'b0, 30'h00000000},
    {1'b0, 30'h3FFFFFFF},
    {1'b0, 30'h15555555},
    {1'b0, 30'h2AAAAAAA},
    {1'b0, 30'h0F0F1234},
    {1'b1, 30'h00000000}
  };

  function automatic logic [1:0] expBp(input int ph, input int which);
    if (which == 1) return (ph == 0) ? 2'b10 : (ph == 2) ? 2'b00 : 2'b01;
    else            return (ph == 1) ? 2'b10 : (ph == 3) ? 2'b00 : 2'b01;
  endfunction

  function automatic logic [NL-1:0] expSeg(input int ph, input logic [2*NL-1:0] st, input logic tst);
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) begin
      logic on;
      on = tst | ((ph % 2 == 0) ? st[2*i] : st[2*i+1]);
      r[i] = (ph < 2) ? ~on : on;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
  endtask

  task automatic nextPhase();
    repeat (TPP) pulseTick();
    cyc(2);
    benchPhase = (benchPhase + 1) % 4;
  endtask

  task automatic checkBp(input string req);
    check(bp1Lvl == expBp(benchPhase, 1), req, 32'(bp1Lvl), 32'(expBp(benchPhase, 1)));
    check(bp2Lvl == expBp(benchPhase, 2), req, 32'(bp2Lvl), 32'(expBp(benchPhase, 2)));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1 reset state
    check(bp1Lvl == 2'b01, "R1 bp1", 32'(bp1Lvl), 32'h1);
    check(bp2Lvl == 2'b01, "R1 bp2", 32'(bp2Lvl), 32'h1);
    check(segLvl == '0, "R1 seg", 32'(segLvl), 32'h0);
    rst_n = 1'b1;
    cyc(2);
    benchPhase = 0;

    // Vector table: each pattern walked over a full frame (R3 R6 R7 R8 R9 R11)
    for (int v = 0; v < 6; v++) begin
      int highCnt [NL];
      segState  = VEC[v][29:0];
      testAllOn = VEC[v][30];
      cyc(2);
      for (int i = 0; i < NL; i++) highCnt[i] = 0;
      for (int p = 0; p < 4; p++) begin
        logic [NL-1:0] e;
        checkBp("R3 R2 R5");
        e = expSeg(benchPhase, segState, testAllOn);
        check(segLvl == e, "R6 R7 R8 R9", 32'(segLvl), 32'(e));
        for (int i = 0; i < NL; i++) highCnt[i] += int'(segLvl[i]);
        nextPhase();
      end
      begin
        bit bal = 1;
        for (int i = 0; i < NL; i++) if (highCnt[i] != 2) bal = 0;
        check(bal, "R11 balance", 32'(highCnt[0]), 32'd2);
      end
    end

    // R4: fewer ticks than a phase needs leave outputs unchanged
    pulseTick();
    cyc(3);
    checkBp("R4 partial tick");
    cyc(5);
    checkBp("R4 no tick");
    pulseTick();
    cyc(2);
    benchPhase = (benchPhase + 1) % 4;
    checkBp("R4 completed count");

    // R10: one edge of latency from input to segment output
    testAllOn = 1'b0;
    segState  = 30'h0000000F;
    cyc(2);
    segState  = 30'h3FFFFFF0;
    cyc(1);
    begin
      logic [NL-1:0] e;
      e = expSeg(benchPhase, segState, 1'b0);
      check(segLvl == e, "R10 latency", 32'(segLvl), 32'(e));
    end
    testAllOn = 1'b1;
    cyc(1);
    begin
      logic [NL-1:0] e;
      e = expSeg(benchPhase, segState, 1'b1);
      check(segLvl == e, "R9 R10 test input", 32'(segLvl), 32'(e));
    end
    testAllOn = 1'b0;

    // R1: reset taken mid-frame restarts at phase 0
    nextPhase();
    rst_n = 1'b0;
    cyc(1);
    check(bp1Lvl == 2'b01 && bp2Lvl == 2'b01, "R1 mid-run bp", {28'h0, bp1Lvl, bp2Lvl}, 32'h5);
    check(segLvl == '0, "R1 mid-run seg", 32'(segLvl), 32'h0);
    rst_n = 1'b1;
    cyc(2);
    benchPhase = 0;
    checkBp("R1 R3 restart phase 0");
    nextPhase();
    checkBp("R3 phase 1 after restart");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule